// File: doc/BRIEF.md
# Descriptor Ring Index Register Bank

This block holds the four index registers of one transfer channel. A channel is a pair of circular queues. In the request queue the host adds work and the device removes it. In the response queue the device adds completions and the host removes them. The host reads the indexes and writes the ones it owns through a small register bus. The device advances its own indexes with single-cycle pop and push strobes. The block works out the occupancy of each queue, and whether it is empty or full, from the indexes.

Each index counts queue elements, not bytes, and wraps modulo the queue depth. The depth is a parameter and must be a power of two. A queue counts as full when it holds depth minus one entries, so one slot always stays unused. The host is told about new completions through a one-cycle interrupt pulse. That pulse is coalesced: it fires only when a completion lands in an empty response queue, or when the device marks the completion as one that must interrupt.

Top module: `ring_ptr_regs`

## Requirements
- R1: After reset all four indexes are 0. Both queues report empty with count 0 and not full. The interrupt and read-valid outputs are low.
- R2: A host write at offset 0x4 sets the request tail, and a write at offset 0x8 sets the response head. Only the low log2(DEPTH) bits of the write data are kept (with DEPTH 8, writing 0xB stores 3).
- R3: Host writes at offset 0x0 (request head) and offset 0xC (response tail) change nothing. Writes are ignored when address bits above bit 11 differ from CHAN_ID, or when address bits 11:4 are not zero.
- R4: Each pop strobe advances the request head by one, modulo DEPTH. A pop while the request queue is empty is ignored.
- R5: Each push strobe advances the response tail by one, modulo DEPTH. A push while the response queue is full is ignored and raises no interrupt.
- R6: The count of each queue is (tail - head) mod DEPTH. Empty means the count is 0, and full means the count is DEPTH-1.
- R7: A read strobe returns its data one cycle later, with read-valid high for that one cycle. The offsets are 0x0 request head, 0x4 request tail, 0x8 response head and 0xC response tail, zero-extended to 32 bits. Any other offset in the window, or a channel mismatch, reads 0.
- R8: An accepted push while the response queue is empty raises the interrupt for exactly the next cycle.
- R9: An accepted push with the force input high raises the interrupt in the next cycle, even when the response queue already holds entries.
- R10: An accepted push without force into a non-empty response queue raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address of a host access |
| bus_wr | input | 1 | Host write strobe |
| bus_rd | input | 1 | Host read strobe |
| bus_wdata | input | 32 | Host write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| dev_req_pop | input | 1 | Device consumed one request |
| dev_rsp_push | input | 1 | Device added one completion |
| dev_rsp_force | input | 1 | Completion must interrupt regardless of queue state |
| req_count | output | log2(DEPTH) | Request queue occupancy |
| req_empty | output | 1 | Request queue empty |
| req_full | output | 1 | Request queue full |
| rsp_count | output | log2(DEPTH) | Response queue occupancy |
| rsp_empty | output | 1 | Response queue empty |
| rsp_full | output | 1 | Response queue full |
| msi_pulse | output | 1 | One-cycle interrupt to the host |

## Verification
The bench fills the response queue to depth minus one and then pushes again with force high. A design that treats the queue as full one slot too late would overwrite the head. A design that lets force bypass the full check would pulse on a completion it dropped. The bench also pushes into a non-empty queue with and without force, which catches a design that interrupts on every completion or never honours force. It writes out-of-range indexes, writes to device-owned offsets and writes with a foreign channel address. A design without masking or decode would then corrupt the indexes that the scoreboarded reads return. Finally, both indexes are driven through the wrap, where an unmasked subtraction would give wrong counts.

// File: rtl/ring_ptr_regs.sv
module ring_ptr_regs #(
  parameter int DEPTH   = 8,
  parameter int ADDR_W  = 16,
  parameter int CHAN_ID = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic                      bus_wr,
  input  logic                      bus_rd,
  input  logic [31:0]               bus_wdata,
  output logic [31:0]               bus_rdata,
  output logic                      bus_rvalid,
  input  logic                      dev_req_pop,
  input  logic                      dev_rsp_push,
  input  logic                      dev_rsp_force,
  output logic [$clog2(DEPTH)-1:0]  req_count,
  output logic                      req_empty,
  output logic                      req_full,
  output logic [$clog2(DEPTH)-1:0]  rsp_count,
  output logic                      rsp_empty,
  output logic                      rsp_full,
  output logic                      msi_pulse
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CH_W  = ADDR_W - 12;
  localparam logic [IDX_W-1:0] FULL_CNT = IDX_W'(DEPTH - 1);

  logic [IDX_W-1:0] req_head, req_tail, rsp_head, rsp_tail;
  logic             sel;
  logic [1:0]       off;
  logic             push_ok, pop_ok;
  logic [IDX_W-1:0] rd_val;
  logic             unused_bits;

  assign sel = (bus_addr[ADDR_W-1:12] == CH_W'(CHAN_ID)) && (bus_addr[11:4] == '0);
  assign off = bus_addr[3:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:IDX_W]};

  assign req_count = req_tail - req_head;
  assign rsp_count = rsp_tail - rsp_head;
  assign req_empty = (req_count == '0);
  assign rsp_empty = (rsp_count == '0);
  assign req_full  = (req_count == FULL_CNT);
  assign rsp_full  = (rsp_count == FULL_CNT);

  assign pop_ok  = dev_req_pop && !req_empty;
  assign push_ok = dev_rsp_push && !rsp_full;

  always_comb begin
    case (off)
      2'd0:    rd_val = req_head;
      2'd1:    rd_val = req_tail;
      2'd2:    rd_val = rsp_head;
      default: rd_val = rsp_tail;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_head   <= '0;
      req_tail   <= '0;
      rsp_head   <= '0;
      rsp_tail   <= '0;
      msi_pulse  <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      if (pop_ok)  req_head <= req_head + 1'b1;
      if (push_ok) rsp_tail <= rsp_tail + 1'b1;
      if (bus_wr && sel && off == 2'd1) req_tail <= bus_wdata[IDX_W-1:0];
      if (bus_wr && sel && off == 2'd2) rsp_head <= bus_wdata[IDX_W-1:0];
      msi_pulse  <= push_ok && (rsp_empty || dev_rsp_force);
      bus_rvalid <= bus_rd;
      bus_rdata  <= (bus_rd && sel) ? 32'(rd_val) : 32'd0;
    end
  end
endmodule

// File: rtl/ring_ptr_regs_chk.sv
module ring_ptr_regs_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_wr,
  input logic bus_rd,
  input logic bus_rvalid,
  input logic dev_req_pop,
  input logic dev_rsp_push,
  input logic dev_rsp_force,
  input logic req_empty,
  input logic rsp_empty,
  input logic rsp_full,
  input logic msi_pulse
);
  p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_req_pop && req_empty && !bus_wr) |=> req_empty);
  p_full_push_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rsp_push && rsp_full && !bus_wr) |=> (rsp_full && !msi_pulse));
  p_rd_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  p_rd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);
  p_msi_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msi_pulse |-> $past(dev_rsp_push));
  p_first_msi_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rsp_push && rsp_empty) |=> msi_pulse);
  p_force_msi_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rsp_push && dev_rsp_force && !rsp_full) |=> msi_pulse);
  p_coalesce_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_rsp_push && !rsp_empty && !dev_rsp_force) |=> !msi_pulse);
endmodule

bind ring_ptr_regs ring_ptr_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_rvalid(bus_rvalid), .dev_req_pop(dev_req_pop),
  .dev_rsp_push(dev_rsp_push), .dev_rsp_force(dev_rsp_force),
  .req_empty(req_empty), .rsp_empty(rsp_empty), .rsp_full(rsp_full),
  .msi_pulse(msi_pulse)
);

// File: tb/ring_ptr_regs_tb.sv
module ring_ptr_regs_tb;
  localparam int DEPTH = 8;
  localparam int IW = 3;

  logic clk = 0, rst_n = 0;
  logic [15:0] bus_addr = '0;
  logic bus_wr = 0, bus_rd = 0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid;
  logic dev_req_pop = 0, dev_rsp_push = 0, dev_rsp_force = 0;
  logic [IW-1:0] req_count, rsp_count;
  logic req_empty, req_full, rsp_empty, rsp_full, msi_pulse;

  int checks = 0, errors = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  ring_ptr_regs #(.DEPTH(DEPTH), .ADDR_W(16), .CHAN_ID(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .dev_req_pop(dev_req_pop), .dev_rsp_push(dev_rsp_push), .dev_rsp_force(dev_rsp_force),
    .req_count(req_count), .req_empty(req_empty), .req_full(req_full),
    .rsp_count(rsp_count), .rsp_empty(rsp_empty), .rsp_full(rsp_full), .msi_pulse(msi_pulse));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (exp_q.size() == 0) check("R7 unexpected rvalid", 1, 0);
      else check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic host_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic host_rd(input logic [15:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1; exp_q.push_back(exp); tag_q.push_back(req);
    @(negedge clk); bus_rd = 0;
    @(negedge clk);
  endtask

  task automatic pop1();
    @(negedge clk); dev_req_pop = 1;
    @(negedge clk); dev_req_pop = 0;
  endtask

  task automatic push1(input logic force_in, input logic exp_msi, input string req);
    @(negedge clk); dev_rsp_push = 1; dev_rsp_force = force_in;
    @(negedge clk); check(req, msi_pulse, exp_msi);
    dev_rsp_push = 0; dev_rsp_force = 0;
  endtask

  initial begin
    #400000;
    check("watchdog", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 req_empty", req_empty, 1);
    check("R1 rsp_empty", rsp_empty, 1);
    check("R1 counts", {req_count, rsp_count}, 0);
    check("R1 full", {req_full, rsp_full}, 0);
    check("R1 msi", msi_pulse, 0);
    check("R1 rvalid", bus_rvalid, 0);
    rst_n = 1;
    host_rd(16'h0, 0, "R1 req head");
    host_rd(16'hC, 0, "R1 rsp tail");

    host_wr(16'h4, 32'hB);
    host_rd(16'h4, 3, "R2 masked req tail");
    check("R6 req_count", req_count, 3);
    host_wr(16'h0, 5);
    host_rd(16'h0, 0, "R3 req head write ignored");
    host_wr(16'h1004, 1);
    host_rd(16'h4, 3, "R3 foreign channel ignored");
    host_wr(16'h0014, 1);
    host_rd(16'h4, 3, "R3 out-of-window offset ignored");

    repeat (3) pop1();
    check("R4 req empty after pops", req_empty, 1);
    pop1();
    host_rd(16'h0, 3, "R4 pop on empty ignored");

    push1(0, 1, "R8 first push msi");
    @(negedge clk); check("R8 single-cycle msi", msi_pulse, 0);
    push1(0, 0, "R10 coalesced push");
    push1(1, 1, "R9 forced msi");
    check("R6 rsp_count", rsp_count, 3);
    for (int i = 0; i < 4; i++) push1(0, 0, "R10 fill");
    check("R6 rsp_full", rsp_full, 1);
    host_wr(16'hC, 2);
    host_rd(16'hC, 7, "R3 rsp tail write ignored");
    push1(1, 0, "R9 R5 forced push on full no msi");
    host_rd(16'hC, 7, "R5 push on full ignored");

    host_wr(16'h8, 7);
    check("R2 rsp empty after head write", rsp_empty, 1);
    host_rd(16'h8, 7, "R2 rsp head");
    push1(0, 1, "R8 msi after drain");
    host_rd(16'hC, 0, "R5 tail wraps");

    host_wr(16'h4, 2);
    check("R6 req wrap count", req_count, 7);
    check("R6 req_full", req_full, 1);
    host_rd(16'h10, 0, "R7 unmapped offset reads 0");
    host_rd(16'h2004, 0, "R7 foreign channel reads 0");

    repeat (3) @(negedge clk);
    check("R7 reads drained", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule